// File: doc/BRIEF.md
# Channel Range-Check Status Unit

This unit watches the data words of thirteen sensing channels: twelve electrodes and one proximity channel. It judges each word against an upper and a lower limit at the moment a calibration pass ends. A pass is either a configuration pass or a reconfiguration pass. The unit keeps one out-of-range bit per channel and two global failure flags, one for each pass type. It presents all of this as two read-only status bytes.

Between passes the status does not move. A channel's bit therefore reflects only the most recent check, and it clears only when a later check finds that channel inside the band. The block does not measure anything, does not search for calibration settings and does not compute the limits. The surrounding logic supplies the channel words, the limits, the completion strobes and the per-type enables.

Top module: `range_status_unit`

## Requirements
- R1: Channels are numbered 0 to 12, and channel 12 is the proximity channel. Channels 0 to 7 appear in `stat0` bits 0 to 7. Channels 8 to 11 appear in `stat1` bits 0 to 3. Channel 12 appears in `stat1` bit 4.
- R2: The top 8 bits of a channel's 10-bit word, taken as `data[9:2]`, are compared with the limits. A channel passes when `lo_lim <= data[9:2] <= hi_lim`, so both limits are inclusive. Any other value fails.
- R3: At an enabled pass, every channel's status bit takes that channel's fail result from the data present in the strobe cycle.
- R4: A set channel bit stays set until a later enabled pass finds that channel inside the band. Changes on the data or limit inputs between passes leave all status unchanged.
- R5: A completion strobe whose enable is low is ignored. Neither status byte changes.
- R6: `stat1` bit 7 is the configuration-fail flag. An enabled configuration pass sets it if any channel fails and clears it if no channel fails. A reconfiguration pass alone leaves it unchanged.
- R7: `stat1` bit 6 is the reconfiguration-fail flag. It follows enabled reconfiguration passes in the same way. A configuration pass alone leaves it unchanged.
- R8: When both enabled strobes arrive in the same cycle, the channel bits and both flags all come from the single check made in that cycle.
- R9: `stat1` bit 5 always reads 0.
- R10: Asynchronous reset clears all status. A synchronous soft reset also clears all status, and it takes priority over a pass strobe in the same cycle.
- R11: The status bytes change on the first rising clock edge that samples a strobe, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous clear of all status |
| ch_data | input | 130 | Channel words; channel i occupies bits [10*i+9 : 10*i] |
| hi_lim | input | 8 | Upper limit, inclusive |
| lo_lim | input | 8 | Lower limit, inclusive |
| cfg_done | input | 1 | One-cycle strobe: configuration pass completed |
| rcfg_done | input | 1 | One-cycle strobe: reconfiguration pass completed |
| cfg_en | input | 1 | Enables checking after configuration passes |
| rcfg_en | input | 1 | Enables checking after reconfiguration passes |
| stat0 | output | 8 | Out-of-range bits of channels 7..0 |
| stat1 | output | 8 | Config-fail, reconfig-fail, 0, proximity, channels 11..8 |

## Verification
A configuration completion and a reconfiguration completion can land in the same cycle. A soft reset can also coincide with either of them. The bench raises both strobes together, with failing data and then with clean data, and expects the channel bits and both global flags to match one shared check. In a further case it pairs a strobe with soft reset and expects both bytes to read zero afterwards.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
  localparam int NCH      = 13;
  localparam int PROX_IDX = 12;

  // Inclusive band test on an already scaled value.
  function automatic logic out_of_band(input logic [7:0] v,
                                       input logic [7:0] lo,
                                       input logic [7:0] hi);
    return (v < lo) || (v > hi);
  endfunction
endpackage

// File: rtl/rsu_cmp.sv
module rsu_cmp #(
  parameter int DATA_W = 10,
  parameter int LIM_W  = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [LIM_W-1:0]  lo,
  input  logic [LIM_W-1:0]  hi,
  output logic              fail
);
  localparam int SHIFT = DATA_W - LIM_W;
  logic [LIM_W-1:0] scaled;

  assign scaled = data[DATA_W-1:SHIFT];
  assign fail   = (scaled < lo) || (scaled > hi);
endmodule

// File: rtl/rsu_bank.sv
module rsu_bank #(
  parameter int NCH    = 13,
  parameter int DATA_W = 10,
  parameter int LIM_W  = 8
) (
  input  logic [NCH*DATA_W-1:0] ch_data,
  input  logic [LIM_W-1:0]      lo,
  input  logic [LIM_W-1:0]      hi,
  output logic [NCH-1:0]        fail_vec
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    rsu_cmp #(.DATA_W(DATA_W), .LIM_W(LIM_W)) u_cmp (
      .data (ch_data[g*DATA_W +: DATA_W]),
      .lo   (lo),
      .hi   (hi),
      .fail (fail_vec[g])
    );
  end
endmodule

// File: rtl/rsu_state.sv
module rsu_state #(
  parameter int NCH = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst,
  input  logic           cfg_evt,
  input  logic           rcfg_evt,
  input  logic [NCH-1:0] fail_vec,
  output logic [NCH-1:0] oor,
  output logic           cfg_fail,
  output logic           rcfg_fail
);
  logic any_fail;
  assign any_fail = |fail_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oor       <= '0;
      cfg_fail  <= 1'b0;
      rcfg_fail <= 1'b0;
    end else if (soft_rst) begin
      oor       <= '0;
      cfg_fail  <= 1'b0;
      rcfg_fail <= 1'b0;
    end else begin
      if (cfg_evt || rcfg_evt) oor <= fail_vec;
      if (cfg_evt)  cfg_fail  <= any_fail;
      if (rcfg_evt) rcfg_fail <= any_fail;
    end
  end
endmodule

// File: rtl/range_status_unit.sv
module range_status_unit #(
  parameter int DATA_W = 10,
  parameter int LIM_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          soft_rst,
  input  logic [rsu_pkg::NCH*DATA_W-1:0] ch_data,
  input  logic [LIM_W-1:0]              hi_lim,
  input  logic [LIM_W-1:0]              lo_lim,
  input  logic                          cfg_done,
  input  logic                          rcfg_done,
  input  logic                          cfg_en,
  input  logic                          rcfg_en,
  output logic [7:0]                    stat0,
  output logic [7:0]                    stat1
);
  localparam int NCH = rsu_pkg::NCH;

  logic           cfg_evt, rcfg_evt;
  logic [NCH-1:0] fail_vec;
  logic [NCH-1:0] oor;
  logic           cfg_fail, rcfg_fail;

  assign cfg_evt  = cfg_done  & cfg_en;
  assign rcfg_evt = rcfg_done & rcfg_en;

  rsu_bank #(.NCH(NCH), .DATA_W(DATA_W), .LIM_W(LIM_W)) u_bank (
    .ch_data  (ch_data),
    .lo       (lo_lim),
    .hi       (hi_lim),
    .fail_vec (fail_vec)
  );

  rsu_state #(.NCH(NCH)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .cfg_evt   (cfg_evt),
    .rcfg_evt  (rcfg_evt),
    .fail_vec  (fail_vec),
    .oor       (oor),
    .cfg_fail  (cfg_fail),
    .rcfg_fail (rcfg_fail)
  );

  assign stat0 = oor[7:0];
  assign stat1 = {cfg_fail, rcfg_fail, 1'b0, oor[rsu_pkg::PROX_IDX], oor[11:8]};
endmodule

// File: rtl/rsu_chk.sv
module rsu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        cfg_evt,
  input logic        rcfg_evt,
  input logic [12:0] fail_vec,
  input logic [7:0]  stat0,
  input logic [7:0]  stat1
);
  p_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_evt || rcfg_evt) && !soft_rst |=> {stat1[4:0], stat0} == $past(fail_vec))
    else $error("p_track_r3");

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_evt || rcfg_evt || soft_rst) |=> $stable(stat0) && $stable(stat1))
    else $error("p_hold_r4");

  p_cfg_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_evt && !soft_rst |=> stat1[7] == $past(|fail_vec))
    else $error("p_cfg_flag_r6");

  p_cfg_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_evt && !soft_rst |=> $stable(stat1[7]))
    else $error("p_cfg_keep_r6");

  p_rcfg_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rcfg_evt && !soft_rst |=> stat1[6] == $past(|fail_vec))
    else $error("p_rcfg_flag_r7");

  p_rcfg_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rcfg_evt && !soft_rst |=> $stable(stat1[6]))
    else $error("p_rcfg_keep_r7");

  p_soft_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> stat0 == 8'h00 && stat1 == 8'h00)
    else $error("p_soft_r10");
endmodule

bind range_status_unit rsu_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .soft_rst (soft_rst),
  .cfg_evt  (cfg_evt),
  .rcfg_evt (rcfg_evt),
  .fail_vec (fail_vec),
  .stat0    (stat0),
  .stat1    (stat1)
);

// File: tb/range_status_unit_tb.sv
module range_status_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         soft_rst = 1'b0;
  logic [129:0] ch_data = '0;
  logic [7:0]   hi_lim = 8'd200;
  logic [7:0]   lo_lim = 8'd50;
  logic         cfg_done = 1'b0, rcfg_done = 1'b0, cfg_en = 1'b1, rcfg_en = 1'b1;
  logic [7:0]   stat0, stat1;

  int n_chk = 0, n_bad = 0;
  logic [12:0] m_oor = '0;
  logic        m_cf = 1'b0, m_rf = 1'b0;

  always #2 clk = ~clk;

  range_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ch_data(ch_data),
    .hi_lim(hi_lim), .lo_lim(lo_lim), .cfg_done(cfg_done), .rcfg_done(rcfg_done),
    .cfg_en(cfg_en), .rcfg_en(rcfg_en), .stat0(stat0), .stat1(stat1)
  );

  function automatic logic [15:0] expect_bytes();
    return {m_cf, m_rf, 1'b0, m_oor[12], m_oor[11:8], m_oor[7:0]};
  endfunction

  task automatic check(input string tag);
    logic [15:0] e = expect_bytes();
    n_chk++;
    if ({stat1, stat0} !== e) begin
      n_bad++;
      $display("FAIL %s: got stat1/stat0=%h expected %h", tag, {stat1, stat0}, e);
    end
  endtask

  task automatic set_ch(input int i, input logic [9:0] v);
    ch_data[i*10 +: 10] = v;
  endtask

  task automatic fill(input logic [9:0] v);
    for (int i = 0; i < 13; i++) set_ch(i, v);
  endtask

  // Model the result of one pass independently from the requirement R2.
  task automatic model_pass(input logic c, input logic r);
    logic [12:0] f;
    for (int i = 0; i < 13; i++) begin
      int s = int'(ch_data[i*10 +: 10]) / 4;
      f[i] = (s < int'(lo_lim)) || (s > int'(hi_lim));
    end
    if (soft_rst) begin
      m_oor = '0; m_cf = 0; m_rf = 0;
    end else begin
      if ((c && cfg_en) || (r && rcfg_en)) m_oor = f;
      if (c && cfg_en) m_cf = |f;
      if (r && rcfg_en) m_rf = |f;
    end
  endtask

  // Apply one cycle of strobes; check before the edge (R11), then after it.
  task automatic step(input logic c, input logic r, input logic s, input string tag);
    @(negedge clk);
    cfg_done = c; rcfg_done = r; soft_rst = s;
    #1 check({tag, " R11 pre-edge"});
    model_pass(c, r);
    @(negedge clk);
    cfg_done = 0; rcfg_done = 0; soft_rst = 0;
    #1 check(tag);
  endtask

  task automatic t_reset();
    check("R10 reset state");
  endtask

  task automatic t_all_pass();
    fill(10'd500);
    step(1, 0, 0, "R2 R6 clean config pass");
  endtask

  task automatic t_map();
    fill(10'd500);
    set_ch(3, 10'd1020);
    set_ch(12, 10'd10);
    set_ch(9, 10'd1000);
    step(1, 0, 0, "R1 R3 R6 R9 map and config flag");
    n_chk++;
    if (stat1[5] !== 1'b0) begin
      n_bad++;
      $display("FAIL R9: bit5=%b expected 0", stat1[5]);
    end
  endtask

  task automatic t_bounds();
    fill(10'd500);
    set_ch(0, {8'd200, 2'b11});
    set_ch(1, {8'd50, 2'b00});
    step(1, 0, 0, "R2 inclusive limits pass");
    set_ch(0, {8'd201, 2'b00});
    set_ch(1, {8'd49, 2'b11});
    step(1, 0, 0, "R2 just outside limits fail");
  endtask

  task automatic t_disabled();
    cfg_en = 0; rcfg_en = 0;
    fill(10'd0);
    step(1, 1, 0, "R5 disabled strobes ignored");
    cfg_en = 1; rcfg_en = 1;
  endtask

  task automatic t_hold();
    fill(10'd1023);
    lo_lim = 8'd0; hi_lim = 8'd10;
    step(0, 0, 0, "R4 hold between passes");
    lo_lim = 8'd50; hi_lim = 8'd200;
    fill(10'd500);
    step(0, 1, 0, "R4 R7 later pass clears");
  endtask

  task automatic t_rcfg();
    fill(10'd500);
    step(1, 0, 0, "R6 clear config flag");
    set_ch(7, 10'd4);
    step(0, 1, 0, "R7 reconfig fail keeps config flag");
  endtask

  task automatic t_both();
    fill(10'd500);
    set_ch(11, 10'd1023);
    step(1, 1, 0, "R8 both strobes failing");
    fill(10'd500);
    step(1, 1, 0, "R8 both strobes clean");
  endtask

  task automatic t_soft();
    fill(10'd0);
    step(1, 0, 0, "R3 all fail");
    step(1, 1, 1, "R10 soft reset beats strobes");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        #1 t_reset();
        rst_n = 1'b1;
        t_all_pass();
        t_map();
        t_bounds();
        t_disabled();
        t_hold();
        t_rcfg();
        t_both();
        t_soft();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule